// File: doc/BRIEF.md
# Reset Source Sequencer with Cause Flags

This block merges the reset requests of a small system into a single active-low system reset. Two sources can request reset: a digitized supply-good level from an external voltage monitor, honoured only while a monitor-enable input is high, and an external active-low reset pin. The monitor level and the enable are brought into the clock domain through two flops. The pin goes through two flops and a glitch filter.

A supply-monitor reset lasts as long as the supply is low. After the supply recovers, reset is held for a further fixed number of clock cycles, set by a parameter. The same sequence applies at first power-up and after any dip, and a new dip during the hold restarts it. A pin reset lasts only as long as the filtered pin stays low.

A read-only status byte records the cause of the last reset. It changes only on the cycle in which the system reset is released. The block's own asynchronous reset `rst_ni` stands for the first application of power. It therefore behaves like a supply-monitor reset.

Top module: `rst_cause_seq`

## Requirements
- R1: While `mon_en_i` is high and `supply_ok_i` is low for at least three consecutive clock edges, `sys_rst_no` is low from the next cycle on.
- R2: After `supply_ok_i` rises with the monitor enabled, `sys_rst_no` rises exactly `HOLD_CYCLES + 3` clock edges later (two synchronizer stages, one state step, then `HOLD_CYCLES` cycles of hold).
- R3: A supply dip while running, or during the hold, forces `sys_rst_no` low again. On recovery, the full hold sequence of R2 restarts from zero.
- R4: At the release that ends a supply-monitor reset, including the first release after `rst_ni`, `status_o` reads 8'h02: bit 1 is the power-on flag, all other bits are 0.
- R5: At the release that ends a pin reset, `status_o` reads 8'h01: bit 0 is the pin flag, and the power-on flag is cleared.
- R6: A low on `ext_rst_ni` lasting at least `FILT_LEN + 3` cycles drives `sys_rst_no` low. On release of the pin, `sys_rst_no` rises exactly `FILT_LEN + 3` edges after the pin goes high, with no extra hold.
- R7: A low pulse on `ext_rst_ni` shorter than `FILT_LEN` cycles has no effect: `sys_rst_no` stays high and `status_o` is unchanged.
- R8: With `mon_en_i` low, a low `supply_ok_i` has no effect on `sys_rst_no` or `status_o`.
- R9: If the supply monitor and the pin both request reset, the release reports the supply-monitor cause (8'h02).
- R10: `status_o` never changes while `sys_rst_no` stays high. At each release, exactly one of its two low bits is set.
- R11: During `rst_ni` low, `sys_rst_no` is low and `status_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset; models first power-up |
| supply_ok_i | input | 1 | Digitized supply-above-threshold level, asynchronous |
| mon_en_i | input | 1 | Supply-monitor reset enable, asynchronous level |
| ext_rst_ni | input | 1 | External active-low reset pin, asynchronous |
| sys_rst_no | output | 1 | Active-low system reset |
| status_o | output | 8 | Reset cause: bit 1 power-on, bit 0 pin, others 0 |

## Verification
The properties assume that `supply_ok_i`, `mon_en_i` and `ext_rst_ni` are clean levels that change at most once per clock cycle. They also assume that `mon_en_i` is changed only while the supply is good, and not within the three cycles that follow a supply change. The stimulus drives all inputs on the falling clock edge and holds each level for whole cycles. It toggles the monitor enable only around supply-good periods. Pin pulses are either clearly shorter than the filter length or at least three cycles longer than it, so every event has one defined outcome.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  typedef enum logic [1:0] {
    ST_MON_HOLD = 2'd0,
    ST_MON_WAIT = 2'd1,
    ST_PIN_HOLD = 2'd2,
    ST_RUN      = 2'd3
  } seq_state_e;

  localparam int unsigned STAT_W     = 8;
  localparam int unsigned STAT_POR   = 1;
  localparam int unsigned STAT_PIN   = 0;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_filt_no
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic pin_s;
  logic filt_q;
  logic [CW-1:0] cnt_q;

  rst_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  // new level accepted only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pin_s != filt_q) begin
      if (cnt_q == CNT_LAST) begin
        filt_q <= pin_s;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign pin_filt_no = filt_q;
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_cause_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              release_i,
  input  logic              cause_mon_i,
  output logic [STAT_W-1:0] status_o
);
  logic por_q, pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b0;
      pin_q <= 1'b0;
    end else if (release_i) begin
      por_q <= cause_mon_i;
      pin_q <= !cause_mon_i;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[STAT_POR] = por_q;
    status_o[STAT_PIN] = pin_q;
  end
endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
  import rst_cause_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 2_500_000,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              mon_en_i,
  input  logic              ext_rst_ni,
  output logic              sys_rst_no,
  output logic [STAT_W-1:0] status_o
);
  logic [1:0] mon_s;
  logic       supply_low;
  logic       pin_filt_n;
  logic       pin_low;
  logic       hold_done;
  logic       release_evt;
  logic       cause_mon_q, cause_mon_d;
  seq_state_e state_q, state_d;

  // bit1: enable (resets to 1), bit0: supply-good (resets to 0)
  rst_sync2 #(.W(2), .RST_VAL(2'b10)) u_mon_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mon_en_i, supply_ok_i}),
    .q_o   (mon_s)
  );

  assign supply_low = mon_s[1] && !mon_s[0];

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_ni     (ext_rst_ni),
    .pin_filt_no(pin_filt_n)
  );

  assign pin_low = !pin_filt_n;

  rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_MON_WAIT),
    .done_o(hold_done)
  );

  always_comb begin
    state_d     = state_q;
    cause_mon_d = cause_mon_q;
    unique case (state_q)
      ST_RUN: begin
        if (supply_low) begin
          state_d     = ST_MON_HOLD;
          cause_mon_d = 1'b1;
        end else if (pin_low) begin
          state_d     = ST_PIN_HOLD;
          cause_mon_d = 1'b0;
        end
      end
      ST_MON_HOLD: begin
        if (!supply_low) state_d = ST_MON_WAIT;
      end
      ST_MON_WAIT: begin
        if (supply_low)     state_d = ST_MON_HOLD;
        else if (hold_done) state_d = pin_low ? ST_PIN_HOLD : ST_RUN;
      end
      ST_PIN_HOLD: begin
        if (supply_low) begin
          state_d     = ST_MON_HOLD;
          cause_mon_d = 1'b1;
        end else if (!pin_low) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_MON_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_MON_HOLD;
      cause_mon_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      cause_mon_q <= cause_mon_d;
    end
  end

  assign release_evt = (state_d == ST_RUN) && (state_q != ST_RUN);

  rst_cause_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .release_i  (release_evt),
    .cause_mon_i(cause_mon_d),
    .status_o   (status_o)
  );

  assign sys_rst_no = (state_q == ST_RUN);
endmodule

// File: rtl/rst_cause_seq_chk.sv
module rst_cause_seq_chk #(
  parameter int unsigned FILT_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       mon_en_i,
  input logic       ext_rst_ni,
  input logic       sys_rst_no,
  input logic [7:0] status_o
);
  localparam int unsigned PIN_MIN = FILT_LEN + 2;
  localparam int unsigned CW = $clog2(PIN_MIN + 2);

  logic [CW-1:0] pin_low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pin_low_cnt_q <= '0;
    else if (ext_rst_ni)                pin_low_cnt_q <= '0;
    else if (pin_low_cnt_q != CW'(PIN_MIN)) pin_low_cnt_q <= pin_low_cnt_q + 1'b1;
  end

  // R1
  mon_low_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_en_i && !supply_ok_i && $past(mon_en_i && !supply_ok_i)
     && $past(mon_en_i && !supply_ok_i, 2)) |=> !sys_rst_no);

  // R6
  pin_low_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rst_ni && pin_low_cnt_q == CW'(PIN_MIN)) |=> !sys_rst_no);

  // R10
  status_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && $past(sys_rst_no)) |-> $stable(status_o));

  // R10
  release_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> ($countones(status_o[1:0]) == 1 && status_o[7:2] == 6'd0));
endmodule

bind rst_cause_seq rst_cause_seq_chk #(.FILT_LEN(FILT_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .mon_en_i   (mon_en_i),
  .ext_rst_ni (ext_rst_ni),
  .sys_rst_no (sys_rst_no),
  .status_o   (status_o)
);

// File: tb/tb_rst_cause_seq.sv
`timescale 1ns/1ps
module tb_rst_cause_seq;
  localparam int unsigned HOLD = 20;
  localparam int unsigned FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       mon_en = 1'b1;
  logic       ext_n = 1'b1;
  logic       sys_rst_n;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_stat = 8'h00;

  always #5 clk = ~clk;

  rst_cause_seq #(.HOLD_CYCLES(HOLD), .FILT_LEN(FILT)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .supply_ok_i(supply_ok),
    .mon_en_i   (mon_en),
    .ext_rst_ni (ext_n),
    .sys_rst_no (sys_rst_n),
    .status_o   (status)
  );

  function automatic logic [7:0] cause_code(input bit by_mon);
    return by_mon ? 8'h02 : 8'h01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (!sys_rst_n && n < HOLD + 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  // count negedges in the window where sys_rst_no is not as expected
  task automatic watch(input int cycles, input logic lvl, output int bad);
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst_n != lvl) bad++;
    end
  endtask

  task automatic ev_dip(input int low_len, input string req);
    int n;
    supply_ok = 1'b0;
    repeat (low_len) @(negedge clk);
    check({req, " R1 held low"}, sys_rst_n, 0);
    supply_ok = 1'b1;
    wait_release(n);
    check({req, " R2 hold length"}, n, HOLD + 3);
    exp_stat = cause_code(1'b1);
    check({req, " R4 status"}, status, exp_stat);
  endtask

  task automatic ev_pin(input int low_len);
    int n;
    ext_n = 1'b0;
    repeat (low_len) @(negedge clk);
    check("R6 pin low", sys_rst_n, 0);
    ext_n = 1'b1;
    wait_release(n);
    check("R6 pin release", n, FILT + 3);
    exp_stat = cause_code(1'b0);
    check("R5 status", status, exp_stat);
  endtask

  task automatic ev_glitch(input int w);
    int bad, b2;
    ext_n = 1'b0;
    watch(w, 1'b1, bad);
    ext_n = 1'b1;
    watch(FILT + 8, 1'b1, b2);
    check("R7 glitch ignored", bad + b2, 0);
    check("R7 status kept", status, exp_stat);
  endtask

  task automatic ev_masked(input int low_len);
    int bad, b2;
    mon_en = 1'b0;
    repeat (4) @(negedge clk);
    supply_ok = 1'b0;
    watch(low_len, 1'b1, bad);
    supply_ok = 1'b1;
    watch(4, 1'b1, b2);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 masked dip", bad + b2, 0);
    check("R8 status kept", status, exp_stat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, bad;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check("R11 reset sys_rst", sys_rst_n, 0);
    check("R11 reset status", status, 8'h00);
    rst_n = 1'b1;
    wait_release(n);
    check("R2 first power-up hold", n, HOLD + 3);
    exp_stat = cause_code(1'b1);
    check("R4 first status", status, exp_stat);
    repeat (5) @(negedge clk);

    ev_pin(FILT + 3);
    repeat (5) @(negedge clk);
    ev_dip(4, "dip");
    repeat (5) @(negedge clk);
    ev_glitch(FILT - 1);
    ev_masked(12);

    // R3: dip again in the middle of the hold restarts it
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    watch(HOLD / 2, 1'b0, bad);
    check("R3 still held mid hold", bad, 0);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    wait_release(n);
    check("R3 restarted hold", n, HOLD + 3);
    check("R4 status after redip", status, cause_code(1'b1));
    repeat (5) @(negedge clk);

    // R9: pin reset first, then supply dip; pin stays low past the hold
    ev_pin(FILT + 3);
    ext_n = 1'b0;
    repeat (FILT + 5) @(negedge clk);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    watch(HOLD + 6, 1'b0, bad);
    check("R9 held by pin after hold", bad, 0);
    ext_n = 1'b1;
    wait_release(n);
    check("R9 release after pin", n, FILT + 3);
    exp_stat = cause_code(1'b1);
    check("R9 supply cause wins", status, exp_stat);
    repeat (5) @(negedge clk);

    for (int k = 0; k < 40; k++) begin
      int kind = $urandom_range(0, 3);
      case (kind)
        0: ev_dip($urandom_range(4, 15), "rnd");
        1: ev_pin($urandom_range(FILT + 3, FILT + 12));
        2: ev_glitch($urandom_range(1, FILT - 1));
        default: ev_masked($urandom_range(3, 20));
      endcase
      watch($urandom_range(3, 10), 1'b1, bad);
      check("R10 running between events", bad, 0);
      check("R10 status stable", status, exp_stat);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule